// File: doc/BRIEF.md
# Transform Coefficient Rescaler

This block turns quantized transform levels back into reconstructed transform coefficients for a video decoder's residual path. Each cycle it can accept one group of signed 16-bit levels, one per lane (four lanes by default). All lanes of a group share one quantization parameter and one block-size code. Each level is scaled by a factor picked by the parameter's remainder modulo six. The product is shifted left by the parameter divided by six, then rounded and shifted right by an amount set by the block size. The result is saturated to 16 bits.

The datapath has two register stages. Results for a group appear two cycles after the group is accepted, together with a valid flag. The quantization parameter and the size code may change on every accepted group, and groups may arrive back to back.

Top module: `coef_rescale`

## Requirements
- R1: While reset is held and in the cycle after it is released, `out_valid` is 0 and every lane of `coef` is 0.
- R2: The quantization parameter `qp` is taken in the range 0 to 51. The scale factor for remainders qp%6 = 0,1,2,3,4,5 is 40,45,51,57,64,72.
- R3: Before rounding, each lane's value is level × scale(qp%6) shifted left by qp/6. This intermediate is kept wide enough that it never overflows.
- R4: The right shift is 5,6,7,8 for `size_code` 0,1,2,3, which selects blocks of 4,8,16,32 points. A rounding offset of 2^(shift−1) is added before the arithmetic right shift.
- R5: A lane's result is clipped to the range −32768 to 32767.
- R6: `out_valid` is 1 exactly two cycles after a cycle with `in_valid` 1. The `coef` lanes carry that group's results in the same cycle.
- R7: Lanes are independent. Lane k of `coef` (bits 16k+15:16k) depends only on lane k of `level` and the shared `qp` and `size_code`.
- R8: A zero level always yields a zero coefficient, for any `qp` and size.
- R9: A positive level never yields a negative coefficient, and a negative level never yields a positive one.
- R10: A new group may be accepted on every cycle with a different `qp` and size, and each group is processed with its own settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Group of levels present this cycle |
| qp | input | 6 | Quantization parameter, 0 to 51 |
| size_code | input | 2 | Block size: 0=4, 1=8, 2=16, 3=32 points |
| level | input | 16*LANES | Signed quantized levels, lane k at bits 16k+15:16k |
| out_valid | output | 1 | Group of coefficients present this cycle |
| coef | output | 16*LANES | Signed rescaled coefficients, lane k at bits 16k+15:16k |

## Verification
The properties assume that `qp` never exceeds 51 when `in_valid` is high and that `in_valid` is low while reset is held. One property checks the first assumption directly. The stimulus keeps within both limits: it walks `qp` only over 0 to 51 for every size code, and it holds `in_valid` low throughout reset. Lane levels include zero, ±1, both 16-bit extremes and a pseudo-random series. The large levels with high `qp` push results into saturation, and the small levels with low `qp` exercise rounding near zero.

// File: rtl/coef_rescale.sv
module coef_rescale #(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [5:0]           qp,
  input  logic [1:0]           size_code,
  input  logic [W*LANES-1:0]   level,
  output logic                 out_valid,
  output logic [W*LANES-1:0]   coef
);
  localparam int PW = W + 18;
  localparam logic signed [PW-1:0] CMAX = PW'((64'sd1 <<< (W-1)) - 1);
  localparam logic signed [PW-1:0] CMIN = -PW'(64'sd1 <<< (W-1));

  function automatic logic [6:0] scale_rom(input logic [2:0] r);
    case (r)
      3'd0: scale_rom = 7'd40;
      3'd1: scale_rom = 7'd45;
      3'd2: scale_rom = 7'd51;
      3'd3: scale_rom = 7'd57;
      3'd4: scale_rom = 7'd64;
      default: scale_rom = 7'd72;
    endcase
  endfunction

  function automatic logic [3:0] shift_rom(input logic [5:0] q);
    if      (q < 6'd6)  shift_rom = 4'd0;
    else if (q < 6'd12) shift_rom = 4'd1;
    else if (q < 6'd18) shift_rom = 4'd2;
    else if (q < 6'd24) shift_rom = 4'd3;
    else if (q < 6'd30) shift_rom = 4'd4;
    else if (q < 6'd36) shift_rom = 4'd5;
    else if (q < 6'd42) shift_rom = 4'd6;
    else if (q < 6'd48) shift_rom = 4'd7;
    else                shift_rom = 4'd8;
  endfunction

  logic [3:0] qdiv;
  logic [2:0] qmod;
  logic [6:0] scale;
  assign qdiv  = shift_rom(qp);
  assign qmod  = 3'(qp - 6'(qdiv) * 6'd6);
  assign scale = scale_rom(qmod);

  logic       v1, v2;
  logic [3:0] rsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1    <= 1'b0;
      v2    <= 1'b0;
      rsh_q <= 4'd5;
    end else begin
      v1    <= in_valid;
      v2    <= v1;
      rsh_q <= 4'd5 + {2'b00, size_code};
    end
  end
  assign out_valid = v2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [W-1:0]  lv;
    logic signed [PW-1:0] prod_d, prod_q, sum, shr;
    logic signed [W-1:0]  res_q;

    assign lv     = level[k*W +: W];
    assign prod_d = (PW'(lv) * $signed({{(PW-7){1'b0}}, scale})) <<< qdiv;
    assign sum    = prod_q + (PW'(1) <<< (rsh_q - 4'd1));
    assign shr    = sum >>> rsh_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q <= '0;
        res_q  <= '0;
      end else begin
        prod_q <= prod_d;
        if (shr > CMAX)      res_q <= CMAX[W-1:0];
        else if (shr < CMIN) res_q <= CMIN[W-1:0];
        else                 res_q <= shr[W-1:0];
      end
    end
    assign coef[k*W +: W] = res_q;
  end
endmodule

// File: rtl/coef_rescale_chk.sv
module coef_rescale_chk #(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [5:0]         qp,
  input logic [1:0]         size_code,
  input logic [W*LANES-1:0] level,
  input logic               out_valid,
  input logic [W*LANES-1:0] coef
);
  // R2 input assumption
  a_r2_qp_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> qp <= 6'd51);

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && level[k*W +: W] == '0) |-> ##2 (coef[k*W +: W] == '0));
    a_r9_sign_pos: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !level[k*W+W-1]) |-> ##2 !coef[k*W+W-1]);
    a_r9_sign_neg: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && level[k*W+W-1]) |-> ##2
        (coef[k*W+W-1] || coef[k*W +: W] == '0));
  end
endmodule

bind coef_rescale coef_rescale_chk #(.LANES(LANES), .W(W)) chk (.*);

// File: tb/coef_rescale_test.sv
`timescale 1ns/1ps
module coef_rescale_test;
  localparam int LANES = 4;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [5:0] qp = '0;
  logic [1:0] size_code = '0;
  logic [W*LANES-1:0] level = '0;
  logic out_valid;
  logic [W*LANES-1:0] coef;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  coef_rescale #(.LANES(LANES), .W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .qp(qp),
    .size_code(size_code), .level(level), .out_valid(out_valid), .coef(coef)
  );

  int scale_t [6] = '{40, 45, 51, 57, 64, 72};

  logic        pv1 = 0, pv2 = 0;
  longint      pc1 [LANES];
  longint      pc2 [LANES];
  longint      pl1 [LANES];
  longint      pl2 [LANES];
  logic [15:0] lfsr = 16'hACE1;

  function automatic longint expect_val(longint lv, int q, int s);
    longint p;
    int sh;
    sh = 5 + s;
    p = (lv * scale_t[q % 6]) <<< (q / 6);
    p = (p + (longint'(1) <<< (sh - 1))) >>> sh;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return p;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic cycle(input logic v, input int q, input int s, input longint lv [LANES]);
    longint act;
    check(out_valid == pv2, "R6 out_valid", out_valid, pv2);
    if (pv2) begin
      for (int k = 0; k < LANES; k++) begin
        act = longint'($signed(coef[k*W +: W]));
        if (pl2[k] == 0)
          check(act == 0, "R8 zero level", act, 0);
        else if (pc2[k] == 32767 || pc2[k] == -32768)
          check(act == pc2[k], "R5 clip", act, pc2[k]);
        else
          check(act == pc2[k], "R3 R4 R7 R10 value", act, pc2[k]);
        if (pl2[k] > 0)
          check(act >= 0, "R9 sign", act, 0);
        else if (pl2[k] < 0)
          check(act <= 0, "R9 sign", act, 0);
      end
    end
    pv2 = pv1;
    pv1 = v;
    for (int k = 0; k < LANES; k++) begin
      pc2[k] = pc1[k];
      pl2[k] = pl1[k];
      pl1[k] = lv[k];
      pc1[k] = v ? expect_val(lv[k], q, s) : 0;
    end
    in_valid = v;
    qp = 6'(q);
    size_code = 2'(s);
    for (int k = 0; k < LANES; k++) level[k*W +: W] = 16'(lv[k]);
    @(negedge clk);
  endtask

  initial begin
    longint lv [LANES];
    for (int k = 0; k < LANES; k++) begin
      pc1[k] = 0; pc2[k] = 0; pl1[k] = 0; pl2[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    check(coef == '0, "R1 reset coef", longint'(coef[15:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && coef == '0, "R1 after release", out_valid, 0);

    // R2 R10 sweep all qp and sizes, back to back
    for (int pat = 0; pat < 6; pat++) begin
      for (int q = 0; q <= 51; q++) begin
        for (int s = 0; s < 4; s++) begin
          for (int k = 0; k < LANES; k++) begin
            case (pat)
              0: lv[k] = 0;
              1: lv[k] = (k % 2 == 0) ? (k + 1) : -(k + 1);
              2: lv[k] = (k % 2 == 0) ? 32767 : -32768;
              3: lv[k] = (k == 0) ? 0 : (k == 1 ? 1234 : (k == 2 ? -777 : 3));
              default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                lv[k] = longint'($signed(lfsr)) >>> (k * 3);
              end
            endcase
          end
          cycle(1'b1, q, s, lv);
        end
      end
      // idle gap
      for (int k = 0; k < LANES; k++) lv[k] = 0;
      cycle(1'b0, 0, 0, lv);
      cycle(1'b0, 0, 0, lv);
    end
    // sparse issue pattern for R6
    for (int i = 0; i < 40; i++) begin
      for (int k = 0; k < LANES; k++) lv[k] = 100 * (k + 1) - 250;
      cycle(i % 3 == 0, i % 52, i % 4, lv);
    end
    for (int k = 0; k < LANES; k++) lv[k] = 0;
    cycle(1'b0, 0, 0, lv);
    cycle(1'b0, 0, 0, lv);
    cycle(1'b0, 0, 0, lv);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule